// File: doc/BRIEF.md
# Four-Level Translation Table Walker

This block turns a 64-bit virtual address into a 48-bit physical address by walking a four-level translation table with a 4 KiB granule, held in memory. A client presents the virtual address together with two table roots: one for the low half of the address space and one for the high half. The walker chooses the root from the top address bits. It then fetches one 64-bit descriptor per level over a single-outstanding read port, and returns the result with a one-cycle completion pulse.

A walk may end early. A block descriptor at level 1 maps 1 GiB and one at level 2 maps 2 MiB. A page descriptor at level 3 maps 4 KiB. Invalid descriptors, reserved encodings and malformed upper address bits end the walk with a fault code and the level at which it stopped. For a successful walk, the attribute fields of the final descriptor are passed out untouched.

Top module: `xw_walker`

## Requirements
- R1: When `req_va[63:48]` is all zeros, the walk starts from `req_base_lo`. When it is all ones, the walk starts from `req_base_hi`. Only bits 47:12 of the selected root are used.
- R2: Any other value of `req_va[63:48]` gives `done` on the cycle after acceptance, with `res_fault` = 2'b10 and `res_level` = 0. No memory read is issued in this case.
- R3: The descriptor read at level L uses address {table base bits 47:12, index, 3'b000}. The index is VA bits 47:39 for L=0, 38:30 for L=1, 29:21 for L=2 and 20:12 for L=3.
- R4: A descriptor with bit 0 = 0 at any level ends the walk with `res_fault` = 2'b01 and `res_level` = that level. In that case `res_pa` and both attribute outputs are zero.
- R5: At levels 0 to 2, descriptor bits 1:0 = 2'b11 is a table descriptor. Its bits 47:12 become the base of the next level's table.
- R6: At level 1, bits 1:0 = 2'b01 is a 1 GiB block: `res_pa` = {desc[47:30], va[29:0]}, `res_level` = 1, `res_fault` = 2'b00.
- R7: At level 2, bits 1:0 = 2'b01 is a 2 MiB block: `res_pa` = {desc[47:21], va[20:0]}, `res_level` = 2, `res_fault` = 2'b00.
- R8: At level 3, bits 1:0 = 2'b11 is a 4 KiB page: `res_pa` = {desc[47:12], va[11:0]}, `res_level` = 3, `res_fault` = 2'b00.
- R9: Bits 1:0 = 2'b01 at level 0 or level 3 is reserved. It gives `res_fault` = 2'b01 at that level, with zero address and attributes.
- R10: On success, `res_attr_hi` equals bits 63:50 and `res_attr_lo` equals bits 11:2 of the final descriptor.
- R11: `mem_rd_valid` stays high with a stable address until `mem_rd_ready`. At most one read is outstanding: no new request is made before the response arrives.
- R12: `done` is high for exactly one cycle, and the `res_*` outputs are valid while it is high. `req_ready` is low from acceptance through the `done` cycle and is high again on the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_va | input | 64 | Virtual address to translate |
| req_base_lo | input | 48 | Root table address for the low half |
| req_base_hi | input | 48 | Root table address for the high half |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Descriptor value |
| done | output | 1 | One-cycle completion pulse |
| res_pa | output | 48 | Translated physical address |
| res_attr_hi | output | 14 | Upper attribute field of the final descriptor |
| res_attr_lo | output | 10 | Lower attribute field of the final descriptor |
| res_level | output | 2 | Level at which the walk ended |
| res_fault | output | 2 | 00 none, 01 translation fault, 10 bad upper address bits |

## Verification
The hardest situation to reach is a walk that passes through three table descriptors and then meets a reserved or invalid encoding at level 3. This needs four chained descriptors whose addresses depend on each other. The bench memory derives every descriptor from a hash of its address, so random addresses produce deep walks on their own. A small override table plants exact descriptor chains for the directed level-0, level-1, level-2 and level-3 endings, including the high-half root. Random handshake delays on both the request and the response side exercise the hold and single-outstanding rules.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int OA_W   = 48;
  localparam int PAGE_W = 12;
  localparam int IDX_W  = 9;
  localparam int DESC_W = 64;
  localparam int NLVL   = 4;
  localparam int LVL_W  = $clog2(NLVL);
  localparam int TB_W   = OA_W - PAGE_W;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_t;
  typedef enum logic [1:0] {K_TABLE, K_LEAF, K_FAULT} kind_t;

  localparam logic [1:0] FLT_NONE  = 2'b00;
  localparam logic [1:0] FLT_XLAT  = 2'b01;
  localparam logic [1:0] FLT_RANGE = 2'b10;

  // number of VA bits carried through unchanged by a leaf at this level
  function automatic int offset_width(lvl_t l);
    return PAGE_W + IDX_W * (NLVL - 1 - int'(l));
  endfunction

  // output address: descriptor supplies the high part, VA the low part
  function automatic logic [OA_W-1:0] leaf_addr(logic [DESC_W-1:0] d,
                                                 logic [OA_W-1:0] va, lvl_t l);
    logic [OA_W-1:0] hi_mask;
    hi_mask = {OA_W{1'b1}} << offset_width(l);
    return (d[OA_W-1:0] & hi_mask) | (va & ~hi_mask);
  endfunction
endpackage

// File: rtl/xw_range_chk.sv
module xw_range_chk
  import xw_pkg::*;
(
  input  logic [63:0]     va,
  input  logic [OA_W-1:0] base_lo,
  input  logic [OA_W-1:0] base_hi,
  output logic            va_ok,
  output logic            hi_sel,
  output logic [TB_W-1:0] root_base
);
  localparam int TOP_W = 64 - OA_W;

  logic all_zero, all_one;
  logic unused_low;

  assign all_zero  = (va[63:OA_W] == {TOP_W{1'b0}});
  assign all_one   = (va[63:OA_W] == {TOP_W{1'b1}});
  assign va_ok     = all_zero | all_one;
  assign hi_sel    = all_one;
  assign root_base = hi_sel ? base_hi[OA_W-1:PAGE_W] : base_lo[OA_W-1:PAGE_W];
  assign unused_low = ^{base_lo[PAGE_W-1:0], base_hi[PAGE_W-1:0], va[OA_W-1:0]};
endmodule

// File: rtl/xw_index_sel.sv
module xw_index_sel
  import xw_pkg::*;
(
  input  logic [OA_W-1:0] va,
  input  lvl_t            lvl,
  input  logic [TB_W-1:0] base,
  output logic [OA_W-1:0] desc_addr
);
  localparam int ENT_W = OA_W - TB_W - IDX_W;

  logic [IDX_W-1:0] slice [NLVL];
  logic unused_off;

  for (genvar g = 0; g < NLVL; g++) begin : g_slice
    assign slice[g] = va[PAGE_W + IDX_W*(NLVL-1-g) +: IDX_W];
  end

  assign desc_addr  = {base, slice[lvl], {ENT_W{1'b0}}};
  assign unused_off = ^va[PAGE_W-1:0];
endmodule

// File: rtl/xw_desc_dec.sv
module xw_desc_dec
  import xw_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  lvl_t              lvl,
  input  logic [OA_W-1:0]   va,
  output kind_t             kind,
  output logic [TB_W-1:0]   next_base,
  output logic [OA_W-1:0]   out_pa,
  output logic [13:0]       attr_hi,
  output logic [9:0]        attr_lo
);
  localparam lvl_t LAST = lvl_t'(NLVL - 1);

  logic is_valid, is_tbl_enc;
  logic unused_rsvd;

  assign is_valid   = desc[0];
  assign is_tbl_enc = desc[1];

  always_comb begin
    if (!is_valid) begin
      kind = K_FAULT;
    end else if (is_tbl_enc) begin
      kind = (lvl == LAST) ? K_LEAF : K_TABLE;
    end else begin
      // block encoding only legal strictly between first and last level
      kind = (lvl != '0 && lvl != LAST) ? K_LEAF : K_FAULT;
    end
  end

  assign next_base   = desc[OA_W-1:PAGE_W];
  assign out_pa      = leaf_addr(desc, va, lvl);
  assign attr_hi     = desc[63:50];
  assign attr_lo     = desc[11:2];
  assign unused_rsvd = ^desc[49:OA_W];
endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_va,
  input  logic [47:0] req_base_lo,
  input  logic [47:0] req_base_hi,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [47:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic [47:0] res_pa,
  output logic [13:0] res_attr_hi,
  output logic [9:0]  res_attr_lo,
  output logic [1:0]  res_level,
  output logic [1:0]  res_fault
);
  st_t             st;
  logic [OA_W-1:0] va_q;
  lvl_t            lvl_q;
  logic [TB_W-1:0] base_q;

  // named events for the checker
  logic accept, accept_bad, rsp_take;

  logic            va_ok, hi_sel;
  logic [TB_W-1:0] root_base;
  kind_t           kind;
  logic [TB_W-1:0] next_base;
  logic [OA_W-1:0] leaf_pa;
  logic [13:0]     d_attr_hi;
  logic [9:0]      d_attr_lo;
  logic            unused_sel;

  xw_range_chk u_range (
    .va(req_va), .base_lo(req_base_lo), .base_hi(req_base_hi),
    .va_ok(va_ok), .hi_sel(hi_sel), .root_base(root_base)
  );

  xw_index_sel u_index (
    .va(va_q), .lvl(lvl_q), .base(base_q), .desc_addr(mem_rd_addr)
  );

  xw_desc_dec u_dec (
    .desc(mem_rsp_data), .lvl(lvl_q), .va(va_q),
    .kind(kind), .next_base(next_base), .out_pa(leaf_pa),
    .attr_hi(d_attr_hi), .attr_lo(d_attr_lo)
  );

  assign unused_sel   = hi_sel;
  assign req_ready    = (st == ST_IDLE);
  assign mem_rd_valid = (st == ST_ISSUE);
  assign done         = (st == ST_DONE);
  assign accept       = req_valid && req_ready;
  assign accept_bad   = accept && !va_ok;
  assign rsp_take     = (st == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      va_q        <= '0;
      lvl_q       <= '0;
      base_q      <= '0;
      res_pa      <= '0;
      res_attr_hi <= '0;
      res_attr_lo <= '0;
      res_level   <= '0;
      res_fault   <= FLT_NONE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            va_q  <= req_va[OA_W-1:0];
            lvl_q <= '0;
            if (va_ok) begin
              base_q <= root_base;
              st     <= ST_ISSUE;
            end else begin
              res_pa      <= '0;
              res_attr_hi <= '0;
              res_attr_lo <= '0;
              res_level   <= '0;
              res_fault   <= FLT_RANGE;
              st          <= ST_DONE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_rd_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_take) begin
            unique case (kind)
              K_TABLE: begin
                base_q <= next_base;
                lvl_q  <= lvl_q + lvl_t'(1);
                st     <= ST_ISSUE;
              end
              K_LEAF: begin
                res_pa      <= leaf_pa;
                res_attr_hi <= d_attr_hi;
                res_attr_lo <= d_attr_lo;
                res_level   <= lvl_q;
                res_fault   <= FLT_NONE;
                st          <= ST_DONE;
              end
              default: begin
                res_pa      <= '0;
                res_attr_hi <= '0;
                res_attr_lo <= '0;
                res_level   <= lvl_q;
                res_fault   <= FLT_XLAT;
                st          <= ST_DONE;
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic [1:0]  res_fault,
  input logic [1:0]  res_level,
  input logic [47:0] res_pa,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [47:0] mem_rd_addr,
  input logic        accept_bad,
  input logic [47:0] va_q
);
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R11
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

  // R3
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[2:0] == 3'b000);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  // R2
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> done && res_fault == 2'b10 && res_level == 2'b00 && !mem_rd_valid);

  // R6
  blk1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault == 2'b00 && res_level == 2'd1 |-> res_pa[29:0] == va_q[29:0]);

  // R8
  page_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault == 2'b00 && res_level == 2'd3 |-> res_pa[11:0] == va_q[11:0]);

  // R9
  leaf_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault == 2'b00 |-> res_level != 2'd0);

  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault != 2'b00 |-> res_pa == 48'd0);
endmodule

bind xw_walker xw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .res_fault(res_fault), .res_level(res_level), .res_pa(res_pa),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .accept_bad(accept_bad), .va_q(va_q)
);

// File: tb/xw_walker_bench.sv
module xw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [47:0] req_base_lo = '0;
  logic [47:0] req_base_hi = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [47:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [47:0] res_pa;
  logic [13:0] res_attr_hi;
  logic [9:0]  res_attr_lo;
  logic [1:0]  res_level;
  logic [1:0]  res_fault;

  always #10 clk = ~clk;

  xw_walker u_xw_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_base_lo(req_base_lo), .req_base_hi(req_base_hi),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .res_pa(res_pa),
    .res_attr_hi(res_attr_hi), .res_attr_lo(res_attr_lo),
    .res_level(res_level), .res_fault(res_fault)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  // memory image: hashed content plus a small override list
  logic [63:0] salt = 64'h1;
  logic [47:0] ov_addr [8];
  logic [63:0] ov_data [8];
  int          ov_n = 0;

  // observed reads
  int          rd_cnt;
  logic [47:0] rd_log [4];

  // expected walk
  logic [47:0] e_addr [4];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ 64'h9E3779B97F4A7C15;
    y = y * 64'hBF58476D1CE4E5B9;
    y = y ^ (y >> 31);
    y = y * 64'h94D049BB133111EB;
    y = y ^ (y >> 29);
    return y;
  endfunction

  function automatic logic [63:0] desc_at(input logic [47:0] a);
    logic [63:0] h;
    for (int i = 0; i < ov_n; i++)
      if (ov_addr[i] == a) return ov_data[i];
    h = mix({16'h0, a} ^ salt);
    case (h[63:61])
      3'd0:    return {h[63:1], 1'b0};
      3'd1:    return {h[63:2], 2'b01};
      default: return {h[63:2], 2'b11};
    endcase
  endfunction

  // bench restatement of the walk
  task automatic model(input logic [63:0] va, input logic [47:0] lo, input logic [47:0] hi,
                       output logic [47:0] pa, output logic [13:0] ah, output logic [9:0] al,
                       output logic [1:0] lvl, output logic [1:0] flt, output int nrd,
                       output bit rsvd);
    logic [35:0] base;
    logic [63:0] d;
    logic [8:0]  idx;
    bit          fin;
    pa = '0; ah = '0; al = '0; lvl = 2'd0; flt = 2'b00; nrd = 0; rsvd = 0; fin = 0;
    if (va[63:48] != 16'h0000 && va[63:48] != 16'hFFFF) begin
      flt = 2'b10;
      return;
    end
    base = (va[63:48] == 16'hFFFF) ? hi[47:12] : lo[47:12];
    for (int l = 0; l < 4 && !fin; l++) begin
      case (l)
        0: idx = va[47:39];
        1: idx = va[38:30];
        2: idx = va[29:21];
        default: idx = va[20:12];
      endcase
      e_addr[l] = {base, idx, 3'b000};
      nrd++;
      d = desc_at(e_addr[l]);
      lvl = 2'(l);
      fin = 1;
      if (!d[0]) begin
        flt = 2'b01;
      end else if (d[1] && l < 3) begin
        base = d[47:12];
        fin = 0;
      end else if (d[1]) begin
        pa = {d[47:12], va[11:0]}; ah = d[63:50]; al = d[11:2];
      end else if (l == 1) begin
        pa = {d[47:30], va[29:0]}; ah = d[63:50]; al = d[11:2];
      end else if (l == 2) begin
        pa = {d[47:21], va[20:0]}; ah = d[63:50]; al = d[11:2];
      end else begin
        flt = 2'b01; rsvd = 1;
      end
    end
  endtask

  // memory responder
  initial begin
    logic [47:0] a;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rd_ready  = 1'b0;
      if (mem_rd_valid) begin
        a = mem_rd_addr;
        chk(a[2:0] == 3'b000, "R3", "read alignment", 64'(a[2:0]), 64'd0);
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(mem_rd_valid && mem_rd_addr == a, "R11", "request held",
              {15'd0, mem_rd_valid, mem_rd_addr}, {16'd1, a});
        end
        if (rd_cnt < 4) rd_log[rd_cnt] = a;
        rd_cnt++;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat ($urandom % 3) begin
          chk(!mem_rd_valid, "R11", "second read outstanding", 64'(mem_rd_valid), 64'd0);
          @(negedge clk);
        end
        mem_rsp_data  = desc_at(a);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_vec++;
        n_bad++;
        $display("FAIL R12 watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic run(input logic [63:0] va, input logic [47:0] lo, input logic [47:0] hi);
    logic [47:0] pa; logic [13:0] ah; logic [9:0] al; logic [1:0] lv, fl;
    int nrd; bit rsvd; string ftag, ptag;
    model(va, lo, hi, pa, ah, al, lv, fl, nrd, rsvd);
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_base_lo = lo; req_base_hi = hi;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (!done) chk(!req_ready, "R12", "ready while busy", 64'(req_ready), 64'd0);
    end
    if (fl == 2'b10) ftag = "R2";
    else if (rsvd) ftag = "R9";
    else if (fl == 2'b01) ftag = "R4";
    else ftag = "R5";
    case (lv)
      2'd1: ptag = "R6";
      2'd2: ptag = "R7";
      2'd3: ptag = "R8";
      default: ptag = "R4";
    endcase
    if (fl != 2'b00) ptag = ftag;
    chk(res_fault == fl, ftag, "fault code", 64'(res_fault), 64'(fl));
    chk(res_level == lv, ftag, "end level", 64'(res_level), 64'(lv));
    chk(res_pa == pa, ptag, "output address", 64'(res_pa), 64'(pa));
    chk({res_attr_hi, res_attr_lo} == {ah, al}, "R10", "attributes",
        64'({res_attr_hi, res_attr_lo}), 64'({ah, al}));
    chk(rd_cnt == nrd, (fl == 2'b10) ? "R2" : "R5", "read count", 64'(rd_cnt), 64'(nrd));
    for (int i = 0; i < nrd && i < 4 && i < rd_cnt; i++)
      chk(rd_log[i] == e_addr[i], (va[63]) ? "R1" : "R3", "descriptor address",
          64'(rd_log[i]), 64'(e_addr[i]));
    @(negedge clk);
    chk(!done && req_ready, "R12", "done pulse width", {62'd0, done, req_ready}, 64'd1);
  endtask

  task automatic ov_set(input int i, input logic [47:0] a, input logic [63:0] d);
    ov_addr[i] = a; ov_data[i] = d;
    if (ov_n < i + 1) ov_n = i + 1;
  endtask

  initial begin
    logic [63:0] va;
    logic [47:0] lo, hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !mem_rd_valid, "R12", "reset state",
        {61'd0, req_ready, done, mem_rd_valid}, 64'd4);

    // R2: malformed top bits
    run(64'h1234_0000_0000_1000, 48'h1000, 48'h2000);
    run(64'h8000_FFFF_FFFF_F000, 48'h1000, 48'h2000);

    // R4: invalid at level 0
    ov_n = 0;
    ov_set(0, 48'h0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFE);
    run(64'h0, 48'h0000_0000_1000, 48'h0);

    // R9: reserved encoding at level 0
    ov_set(0, 48'h0000_0000_1000, 64'h0000_0000_0000_3001);
    run(64'h0, 48'h0000_0000_1000, 48'h0);

    // R6: 1 GiB block at level 1 (va idx L0=1, L1=2)
    ov_n = 0;
    ov_set(0, 48'h0000_0000_1008, 64'h0000_0000_0000_2003);
    ov_set(1, 48'h0000_0000_2010, 64'hABCD_0012_C000_0F41);
    run(64'h0000_0080_A123_4567, 48'h0000_0000_1000, 48'h0);

    // R7: 2 MiB block at level 2
    ov_set(1, 48'h0000_0000_2010, 64'h0000_0000_0000_3003);
    ov_set(2, 48'h0000_0000_3000 + 48'(64'h0000_0080_A123_4567 >> 21 & 9'h1FF) * 8,
           64'h5555_0000_7FE0_0AA5);
    run(64'h0000_0080_A123_4567, 48'h0000_0000_1000, 48'h0);

    // R8 + R1: 4 KiB page via high-half root
    ov_n = 0;
    ov_set(0, 48'h0000_0004_5FF8, 64'h0000_0000_0000_6003);
    ov_set(1, 48'h0000_0000_6FF8, 64'h0000_0000_0000_7003);
    ov_set(2, 48'h0000_0000_7FF8, 64'h0000_0000_0000_8003);
    ov_set(3, 48'h0000_0000_8FF8, 64'hFFFC_0000_1234_5FFF);
    run(64'hFFFF_FFFF_FFFF_FABC, 48'h0000_0000_1000, 48'h0000_0004_5000);

    // R9: reserved encoding at level 3
    ov_set(3, 48'h0000_0000_8FF8, 64'h0000_0000_1234_5001);
    run(64'hFFFF_FFFF_FFFF_FABC, 48'h0000_0000_1000, 48'h0000_0004_5000);

    // R4: invalid at level 3
    ov_set(3, 48'h0000_0000_8FF8, 64'h0000_0000_1234_5FFE);
    run(64'hFFFF_FFFF_FFFF_FABC, 48'h0000_0000_1000, 48'h0000_0004_5000);

    // random walks over hashed tables
    ov_n = 0;
    for (int t = 0; t < 400; t++) begin
      salt = {$urandom, $urandom};
      va = {$urandom, $urandom};
      case ($urandom % 5)
        0, 1:    va[63:48] = 16'h0000;
        2, 3:    va[63:48] = 16'hFFFF;
        default: va[63:48] = 16'($urandom);
      endcase
      lo = {16'($urandom), $urandom};
      hi = {16'($urandom), $urandom};
      run(va, lo, hi);
    end

    finish_run();
  end
endmodule